// File: doc/BRIEF.md
# Card State and Bus Width Tracker

This block sits on the controller side of a memory-card host and follows the command traffic so that the rest of the controller always knows the card's state and the data bus width. It watches each command as it is issued: a one-cycle strobe with a 6-bit command index, a flag marking an application-specific command, and a 32-bit argument. Later it sees the command's completion or failure, and for single-block reads the end of the data phase. From these it keeps a model of the selected card. The card can be idle, identifying, standing by, ready for transfers, or moving data. The block also keeps the bus width, which is either one lane or four.

The legality of each tracked command is decided when the command is issued. An illegal command raises a flag for one cycle and is dropped. A legal command that changes the model waits in a single pending slot until its completion arrives. A failure discards it. The go-idle command acts at once, from any state, and cancels anything pending. A width change is accepted only while the card is selected and in the transfer state. Commands the tracker does not model pass through without effect.

Top module: `card_mode_tracker`

## Requirements
- R1: After reset, `card_state` is 0 (idle), `bus_wide` is 0 (one lane) and `cmd_illegal` is 0. The state encoding is idle=0, identification=1, standby=2, transfer=3, data=4.
- R2: Index 0 issued without the application flag (go-idle) sets the state to idle and the width to one lane on the next clock, from any state. Any pending command is discarded, so a later completion has no effect.
- R3: Index 2 completed while idle moves the state to identification. Index 3 completed in identification or standby moves the state to standby.
- R4: The card address is argument bits [31:16]. Index 7 with a nonzero address, completed in standby or transfer, moves the state to transfer. With a zero address it moves the state to standby.
- R5: Index 6 with the application flag (width change) completed in transfer sets the width from argument bits [1:0]. 2'b10 selects four lanes (`bus_wide`=1) and 2'b00 selects one lane (`bus_wide`=0).
- R6: A width change issued outside the transfer state pulses `cmd_illegal` for exactly one cycle and leaves the width unchanged.
- R7: A width change issued in transfer with argument bits [1:0] of 2'b01 or 2'b11 is illegal. It pulses `cmd_illegal` and leaves the width unchanged.
- R8: Index 17 completed in transfer moves the state to data. `xfer_done` in data returns the state to transfer. Index 12 completed in data also returns it to transfer.
- R9: `cmd_fail` discards the pending command with no change to state or width. A `cmd_done` with nothing pending has no effect.
- R10: A tracked command (index 2, 3, 7, 12, 17, or application index 6) issued in a state that does not allow it, or while another tracked command is pending, pulses `cmd_illegal` on the next cycle and is dropped.
- R11: Any other index, including index 6 without the application flag, is never flagged and changes neither state nor width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_issue | input | 1 | One-cycle strobe: a command is issued |
| cmd_index | input | 6 | Command index |
| cmd_app | input | 1 | Command is an application-specific command |
| cmd_arg | input | 32 | Command argument |
| cmd_done | input | 1 | Pending command completed with a good response |
| cmd_fail | input | 1 | Pending command failed |
| xfer_done | input | 1 | Single-block data phase finished |
| bus_wide | output | 1 | 1 = four data lanes, 0 = one lane |
| card_state | output | 3 | Modelled card state (encoding in R1) |
| cmd_illegal | output | 1 | One-cycle pulse: the last issued command was illegal |

## Verification
The bench builds the block with its default parameters: a 6-bit index, a 32-bit argument, the card address in bits [31:16] and a 2-bit width code in bits [1:0]. With these values the bench can show that a zero address is told apart from a nonzero one by the upper half of the argument alone, and that all four width codes are reached. The directed scenarios walk the card through every state. They probe each tracked command both in states that allow it and in states that do not. They also cover the pending slot's edges: a completion, a failure, a second command while busy, and a go-idle that cancels a pending command.

// File: rtl/sdtrk_pkg.sv
package sdtrk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_IDENT = 3'd1,
    ST_STBY  = 3'd2,
    ST_TRAN  = 3'd3,
    ST_DATA  = 3'd4
  } card_st_e;

  // tracked command indices
  localparam int unsigned IX_GO_IDLE   = 0;
  localparam int unsigned IX_ALL_ID    = 2;
  localparam int unsigned IX_REL_ADDR  = 3;
  localparam int unsigned IX_WIDTH     = 6;
  localparam int unsigned IX_SELECT    = 7;
  localparam int unsigned IX_STOP      = 12;
  localparam int unsigned IX_RD_SINGLE = 17;

  // width codes in the low argument bits
  localparam int unsigned WCODE_NARROW = 0;
  localparam int unsigned WCODE_WIDE   = 2;

  typedef struct packed {
    logic     upd_state;
    card_st_e nxt_state;
    logic     upd_width;
    logic     wide;
  } cmd_effect_t;

endpackage

// File: rtl/sdtrk_cmd_check.sv
module sdtrk_cmd_check
  import sdtrk_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int RCA_W  = 16,
  parameter int CODE_W = 2
) (
  input  card_st_e          state,
  input  logic              busy,
  input  logic              issue,
  input  logic [IDX_W-1:0]  idx,
  input  logic              app,
  input  logic [RCA_W-1:0]  rca,
  input  logic [CODE_W-1:0] code,
  output logic              go_idle,
  output logic              take,
  output logic              bad,
  output cmd_effect_t       eff
);

  localparam logic [IDX_W-1:0]  I_GO    = IDX_W'(IX_GO_IDLE);
  localparam logic [IDX_W-1:0]  I_ALL   = IDX_W'(IX_ALL_ID);
  localparam logic [IDX_W-1:0]  I_REL   = IDX_W'(IX_REL_ADDR);
  localparam logic [IDX_W-1:0]  I_WID   = IDX_W'(IX_WIDTH);
  localparam logic [IDX_W-1:0]  I_SEL   = IDX_W'(IX_SELECT);
  localparam logic [IDX_W-1:0]  I_STOP  = IDX_W'(IX_STOP);
  localparam logic [IDX_W-1:0]  I_RD    = IDX_W'(IX_RD_SINGLE);
  localparam logic [CODE_W-1:0] C_NAR   = CODE_W'(WCODE_NARROW);
  localparam logic [CODE_W-1:0] C_WIDE  = CODE_W'(WCODE_WIDE);

  logic known;
  logic wrong;
  logic rca_zero;

  assign rca_zero = (rca == '0);

  always_comb begin
    eff           = '0;
    eff.nxt_state = state;
    go_idle       = 1'b0;
    known         = 1'b0;
    wrong         = 1'b0;
    if (issue) begin
      if (!app && idx == I_GO) begin
        go_idle = 1'b1;
      end else if (app) begin
        if (idx == I_WID) begin
          known = 1'b1;
          if (state != ST_TRAN || !(code == C_NAR || code == C_WIDE)) begin
            wrong = 1'b1;
          end else begin
            eff.upd_width = 1'b1;
            eff.wide      = (code == C_WIDE);
          end
        end
      end else begin
        case (idx)
          I_ALL: begin
            known = 1'b1;
            if (state == ST_IDLE) begin
              eff.upd_state = 1'b1;
              eff.nxt_state = ST_IDENT;
            end else begin
              wrong = 1'b1;
            end
          end
          I_REL: begin
            known = 1'b1;
            if (state == ST_IDENT || state == ST_STBY) begin
              eff.upd_state = 1'b1;
              eff.nxt_state = ST_STBY;
            end else begin
              wrong = 1'b1;
            end
          end
          I_SEL: begin
            known = 1'b1;
            if (state == ST_STBY || state == ST_TRAN) begin
              eff.upd_state = 1'b1;
              eff.nxt_state = rca_zero ? ST_STBY : ST_TRAN;
            end else begin
              wrong = 1'b1;
            end
          end
          I_RD: begin
            known = 1'b1;
            if (state == ST_TRAN) begin
              eff.upd_state = 1'b1;
              eff.nxt_state = ST_DATA;
            end else begin
              wrong = 1'b1;
            end
          end
          I_STOP: begin
            known = 1'b1;
            if (state == ST_DATA) begin
              eff.upd_state = 1'b1;
              eff.nxt_state = ST_TRAN;
            end else begin
              wrong = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
    bad  = known && (wrong || busy);
    take = known && !bad;
    if (bad) begin
      eff           = '0;
      eff.nxt_state = state;
    end
  end

endmodule

// File: rtl/sdtrk_pending.sv
module sdtrk_pending
  import sdtrk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  cmd_effect_t eff_in,
  input  logic        go_idle,
  input  logic        cmd_done,
  input  logic        cmd_fail,
  output logic        busy,
  output logic        apply,
  output cmd_effect_t eff_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      eff_out <= '0;
    end else if (go_idle) begin
      busy    <= 1'b0;
    end else if (busy && (cmd_done || cmd_fail)) begin
      busy    <= 1'b0;
    end else if (take) begin
      busy    <= 1'b1;
      eff_out <= eff_in;
    end
  end

  assign apply = busy && cmd_done && !go_idle;

  // R10: a held slot keeps its contents until completion, failure or go-idle
  p_slot_hold_r10: assert property (@(posedge clk) disable iff (rst)
    busy && !cmd_done && !cmd_fail && !go_idle |=> busy && $stable(eff_out));

  // R9: completion or failure always frees the slot
  p_slot_free_r9: assert property (@(posedge clk) disable iff (rst)
    busy && (cmd_done || cmd_fail) |=> !busy);

endmodule

// File: rtl/sdtrk_state_reg.sv
module sdtrk_state_reg
  import sdtrk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go_idle,
  input  logic        apply,
  input  cmd_effect_t eff,
  input  logic        xfer_done,
  output card_st_e    state
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else if (go_idle) begin
      state <= ST_IDLE;
    end else if (apply && eff.upd_state) begin
      state <= eff.nxt_state;
    end else if (xfer_done && state == ST_DATA) begin
      state <= ST_TRAN;
    end
  end

  p_go_idle_state_r2: assert property (@(posedge clk) disable iff (rst)
    go_idle |=> state == ST_IDLE);

  p_data_exit_r8: assert property (@(posedge clk) disable iff (rst)
    state == ST_DATA && xfer_done && !go_idle |=> state == ST_TRAN);

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !go_idle && !apply && !xfer_done |=> $stable(state));

endmodule

// File: rtl/sdtrk_width_reg.sv
module sdtrk_width_reg
  import sdtrk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go_idle,
  input  logic        apply,
  input  cmd_effect_t eff,
  input  card_st_e    state,
  output logic        wide
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wide <= 1'b0;
    end else if (go_idle) begin
      wide <= 1'b0;
    end else if (apply && eff.upd_width) begin
      wide <= eff.wide;
    end
  end

  p_go_idle_narrow_r2: assert property (@(posedge clk) disable iff (rst)
    go_idle |=> !wide);

  p_width_in_tran_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(wide) |-> $past(go_idle) || $past(state) == ST_TRAN);

endmodule

// File: rtl/card_mode_tracker.sv
module card_mode_tracker
  import sdtrk_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ARG_W   = 32,
  parameter int RCA_LSB = 16,
  parameter int RCA_W   = 16,
  parameter int CODE_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_issue,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic             cmd_app,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             cmd_done,
  input  logic             cmd_fail,
  input  logic             xfer_done,
  output logic             bus_wide,
  output logic [2:0]       card_state,
  output logic             cmd_illegal
);

  localparam int RCA_TOP = RCA_LSB + RCA_W;

  card_st_e    state;
  cmd_effect_t dec_eff;
  cmd_effect_t pend_eff;
  logic        go_idle;
  logic        take;
  logic        bad;
  logic        busy;
  logic        apply;
  logic        unused_mid;
  logic        unused_top;

  generate
    if (RCA_LSB > CODE_W) begin : g_mid
      assign unused_mid = ^cmd_arg[RCA_LSB-1:CODE_W];
    end else begin : g_nomid
      assign unused_mid = 1'b0;
    end
    if (ARG_W > RCA_TOP) begin : g_top
      assign unused_top = ^cmd_arg[ARG_W-1:RCA_TOP];
    end else begin : g_notop
      assign unused_top = 1'b0;
    end
  endgenerate

  sdtrk_cmd_check #(
    .IDX_W (IDX_W),
    .RCA_W (RCA_W),
    .CODE_W(CODE_W)
  ) u_check (
    .state  (state),
    .busy   (busy),
    .issue  (cmd_issue),
    .idx    (cmd_index),
    .app    (cmd_app),
    .rca    (cmd_arg[RCA_LSB +: RCA_W]),
    .code   (cmd_arg[CODE_W-1:0]),
    .go_idle(go_idle),
    .take   (take),
    .bad    (bad),
    .eff    (dec_eff)
  );

  sdtrk_pending u_pend (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .eff_in  (dec_eff),
    .go_idle (go_idle),
    .cmd_done(cmd_done),
    .cmd_fail(cmd_fail),
    .busy    (busy),
    .apply   (apply),
    .eff_out (pend_eff)
  );

  sdtrk_state_reg u_state (
    .clk      (clk),
    .rst      (rst),
    .go_idle  (go_idle),
    .apply    (apply),
    .eff      (pend_eff),
    .xfer_done(xfer_done),
    .state    (state)
  );

  sdtrk_width_reg u_width (
    .clk    (clk),
    .rst    (rst),
    .go_idle(go_idle),
    .apply  (apply),
    .eff    (pend_eff),
    .state  (state),
    .wide   (bus_wide)
  );

  always_ff @(posedge clk) begin
    if (rst) cmd_illegal <= 1'b0;
    else     cmd_illegal <= bad;
  end

  assign card_state = state;

  p_illegal_follows_issue_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_illegal |-> $past(cmd_issue));

  p_illegal_no_effect_r6: assert property (@(posedge clk) disable iff (rst)
    bad && !busy |=> $stable(bus_wide) && $stable(card_state));

endmodule

// File: tb/test_card_mode_tracker.sv
module test_card_mode_tracker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_issue = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic        cmd_app = 1'b0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_done = 1'b0;
  logic        cmd_fail = 1'b0;
  logic        xfer_done = 1'b0;
  logic        bus_wide;
  logic [2:0]  card_state;
  logic        cmd_illegal;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  localparam int S_IDLE = 0, S_IDENT = 1, S_STBY = 2, S_TRAN = 3, S_DATA = 4;
  localparam logic [31:0] RCA_ARG = 32'hA5C3_0000;

  always #4 clk = ~clk;

  card_mode_tracker i_card_mode_tracker (
    .clk(clk), .rst(rst), .cmd_issue(cmd_issue), .cmd_index(cmd_index),
    .cmd_app(cmd_app), .cmd_arg(cmd_arg), .cmd_done(cmd_done),
    .cmd_fail(cmd_fail), .xfer_done(xfer_done), .bus_wide(bus_wide),
    .card_state(card_state), .cmd_illegal(cmd_illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int idx, input bit app, input logic [31:0] arg);
    @(negedge clk);
    cmd_issue = 1'b1; cmd_index = idx[5:0]; cmd_app = app; cmd_arg = arg;
    @(negedge clk);
    cmd_issue = 1'b0; cmd_index = '0; cmd_app = 1'b0; cmd_arg = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  task automatic pulse_fail();
    @(negedge clk); cmd_fail = 1'b1;
    @(negedge clk); cmd_fail = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic run_cmd(input string tag, input int idx, input bit app,
                         input logic [31:0] arg, input bit exp_bad);
    issue(idx, app, arg);
    chk({tag, " illegal flag"}, int'(cmd_illegal), int'(exp_bad));
    if (!exp_bad) pulse_done();
  endtask

  task automatic goto_tran();
    issue(0, 1'b0, 32'h0);
    run_cmd("R3 setup", 2, 1'b0, 32'h0, 1'b0);
    run_cmd("R3 setup", 3, 1'b0, 32'h0, 1'b0);
    run_cmd("R4 setup", 7, 1'b0, RCA_ARG, 1'b0);
    chk("R4 setup state", int'(card_state), S_TRAN);
  endtask

  task automatic t_reset_r1();
    chk("R1 state", int'(card_state), S_IDLE);
    chk("R1 width", int'(bus_wide), 0);
    chk("R1 illegal", int'(cmd_illegal), 0);
  endtask

  task automatic t_ident_r3();
    run_cmd("R3 idx2", 2, 1'b0, 32'h0, 1'b0);
    chk("R3 ident state", int'(card_state), S_IDENT);
    run_cmd("R3 idx3", 3, 1'b0, 32'h0, 1'b0);
    chk("R3 standby state", int'(card_state), S_STBY);
    run_cmd("R3 idx3 again", 3, 1'b0, 32'h0, 1'b0);
    chk("R3 standby kept", int'(card_state), S_STBY);
  endtask

  task automatic t_select_r4();
    run_cmd("R4 select", 7, 1'b0, RCA_ARG, 1'b0);
    chk("R4 transfer", int'(card_state), S_TRAN);
    run_cmd("R4 deselect", 7, 1'b0, 32'h0000_FFFF, 1'b0);
    chk("R4 standby", int'(card_state), S_STBY);
    run_cmd("R4 reselect", 7, 1'b0, 32'h0001_0000, 1'b0);
    chk("R4 transfer again", int'(card_state), S_TRAN);
  endtask

  task automatic t_width_r5();
    run_cmd("R5 wide", 6, 1'b1, 32'h2, 1'b0);
    chk("R5 four lanes", int'(bus_wide), 1);
    run_cmd("R5 narrow", 6, 1'b1, 32'h0, 1'b0);
    chk("R5 one lane", int'(bus_wide), 0);
    run_cmd("R5 wide again", 6, 1'b1, 32'hFFFF_FFF2, 1'b0);
    chk("R5 four lanes again", int'(bus_wide), 1);
    chk("R5 state kept", int'(card_state), S_TRAN);
  endtask

  task automatic t_bad_code_r7();
    run_cmd("R7 code01", 6, 1'b1, 32'h1, 1'b1);
    pulse_done();
    chk("R7 width kept 01", int'(bus_wide), 1);
    run_cmd("R7 code11", 6, 1'b1, 32'h3, 1'b1);
    pulse_done();
    chk("R7 width kept 11", int'(bus_wide), 1);
  endtask

  task automatic t_outside_r6();
    run_cmd("R6 narrow first", 6, 1'b1, 32'h0, 1'b0);
    run_cmd("R6 deselect", 7, 1'b0, 32'h0, 1'b0);
    chk("R6 in standby", int'(card_state), S_STBY);
    issue(6, 1'b1, 32'h2);
    chk("R6 illegal pulse", int'(cmd_illegal), 1);
    @(negedge clk);
    chk("R6 pulse one cycle", int'(cmd_illegal), 0);
    pulse_done();
    chk("R6 width unchanged", int'(bus_wide), 0);
    chk("R6 state unchanged", int'(card_state), S_STBY);
  endtask

  task automatic t_untracked_r11();
    run_cmd("R11 plain idx6", 6, 1'b0, 32'h2, 1'b0);
    chk("R11 width", int'(bus_wide), 0);
    chk("R11 state", int'(card_state), S_TRAN);
    run_cmd("R11 idx13", 13, 1'b0, 32'h0, 1'b0);
    chk("R11 idx13 state", int'(card_state), S_TRAN);
    run_cmd("R11 app idx41", 41, 1'b1, 32'h0, 1'b0);
    chk("R11 app idx41 state", int'(card_state), S_TRAN);
  endtask

  task automatic t_data_r8();
    run_cmd("R8 read", 17, 1'b0, 32'h0, 1'b0);
    chk("R8 data state", int'(card_state), S_DATA);
    pulse_xfer();
    chk("R8 back to transfer", int'(card_state), S_TRAN);
    pulse_xfer();
    chk("R8 xfer in transfer ignored", int'(card_state), S_TRAN);
    run_cmd("R8 read2", 17, 1'b0, 32'h0, 1'b0);
    run_cmd("R8 stop", 12, 1'b0, 32'h0, 1'b0);
    chk("R8 stop to transfer", int'(card_state), S_TRAN);
  endtask

  task automatic t_fail_r9();
    issue(7, 1'b0, 32'h0);
    pulse_fail();
    chk("R9 fail keeps state", int'(card_state), S_TRAN);
    pulse_done();
    chk("R9 stray done no effect", int'(card_state), S_TRAN);
  endtask

  task automatic t_order_r10();
    run_cmd("R10 stop in transfer", 12, 1'b0, 32'h0, 1'b1);
    run_cmd("R10 idx2 in transfer", 2, 1'b0, 32'h0, 1'b1);
    chk("R10 state after wrong", int'(card_state), S_TRAN);
    issue(17, 1'b0, 32'h0);
    chk("R10 read accepted", int'(cmd_illegal), 0);
    issue(6, 1'b1, 32'h2);
    chk("R10 busy illegal", int'(cmd_illegal), 1);
    pulse_done();
    chk("R10 read applied", int'(card_state), S_DATA);
    chk("R10 busy width dropped", int'(bus_wide), 0);
    run_cmd("R10 idx17 in data", 17, 1'b0, 32'h0, 1'b1);
    pulse_xfer();
  endtask

  task automatic t_go_idle_r2();
    run_cmd("R2 wide", 6, 1'b1, 32'h2, 1'b0);
    run_cmd("R2 read", 17, 1'b0, 32'h0, 1'b0);
    issue(0, 1'b0, 32'h0);
    chk("R2 idle state", int'(card_state), S_IDLE);
    chk("R2 narrow", int'(bus_wide), 0);
    chk("R2 not illegal", int'(cmd_illegal), 0);
    issue(2, 1'b0, 32'h0);
    issue(0, 1'b0, 32'h0);
    pulse_done();
    chk("R2 cancelled pending", int'(card_state), S_IDLE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_ident_r3();
    t_select_r4();
    t_width_r5();
    t_bad_code_r7();
    t_outside_r6();
    run_cmd("R4 reselect", 7, 1'b0, RCA_ARG, 1'b0);
    t_untracked_r11();
    t_data_r8();
    t_fail_r9();
    t_order_r10();
    goto_tran();
    t_go_idle_r2();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (R1..all): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule